// File: doc/BRIEF.md
# QoS Tag Configuration Register Unit

This unit holds a supervisor-level resource-management configuration register that tags the running software with two 12-bit identifiers: a resource-control tag in bits 11:0 and a monitoring-counter tag in bits 27:16. It also holds the single machine-level enable bit that decides whether supervisor software may touch that register. The core's CSR stage presents one request per cycle: an address, an operation, an operand and the current privilege. The unit answers in the same cycle with the old value, or with an illegal-access flag, and commits any write on the next clock edge.

The configuration register sits at CSR address 0x181. The enable bit is bit 55 of the 64-bit machine state-enable register 0. With `XLEN` = 64 that register is at 0x30C. With `XLEN` = 32 its upper half is at 0x31C, where the enable bit is bit 23, and its lower half at 0x30C reads as zero.

Top module: `qos_tag_csr`

## Requirements
- R1: After reset both identifier tags are zero and the supervisor enable bit is zero.
- R2: A machine-mode request (priv 2'b11) to 0x181 is always permitted. It returns `{4'b0, mcid, 4'b0, rcid}` in bits 31:0 in the same cycle, with all higher bits zero.
- R3: A write (op 2'b01) to 0x181 loads operand bits 11:0 into the resource-control tag and operand bits 27:16 into the monitoring tag. The next read returns the updated register.
- R4: Bits 15:12 and 31:28 of the register, and every bit above 31, read as zero and ignore writes.
- R5: Set (op 2'b10) and clear (op 2'b11) form the new value as current OR operand, or current AND NOT operand. The result is then split into the two tags in the same way as a write.
- R6: A set or clear with an all-zero operand performs no write.
- R7: A supervisor request (priv 2'b01) to 0x181 is permitted only while the enable bit is 1. Otherwise it is illegal.
- R8: A user-mode request (priv 2'b00) to 0x181 is always illegal.
- R9: The state-enable register is machine-only. Only the enable bit is held; every other bit reads as zero. Set, clear and write act on the enable bit as they act on the tags.
- R10: A request that is not permitted raises `illegal` in the same cycle, returns zero read data and changes no state.
- R11: A request to any address outside this unit is illegal. Op 2'b00 means no request: `illegal` is low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 2 | 00 none, 01 write, 10 set, 11 clear |
| req_addr | input | 12 | CSR address |
| req_priv | input | 2 | 00 user, 01 supervisor, 11 machine |
| req_wdata | input | XLEN | Operand |
| rd_data | output | XLEN | Old value of the addressed register, zero if not permitted |
| illegal | output | 1 | Request not permitted |

## Verification
The tag register is written with all ones, which shows that the reserved gaps and the upper word stay zero. Clear and set operands then flip single bits in both tags, which tells a correct OR or AND-NOT apart from a plain overwrite. A write that touches only reserved bits separates field legalization from a raw copy of the operand. The same supervisor and user requests are repeated with the enable bit clear, set and clear again, which tells real gating apart from a fixed privilege rule. Zero-operand set and clear requests, unknown addresses and an idle cycle cover the cases where nothing may be written.

// File: rtl/qos_tag_csr.sv
module qos_tag_csr #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      req_op,
  input  logic [11:0]     req_addr,
  input  logic [1:0]      req_priv,
  input  logic [XLEN-1:0] req_wdata,
  output logic [XLEN-1:0] rd_data,
  output logic            illegal
);
  localparam logic [11:0] QOS_ADDR = 12'h181;
  localparam logic [11:0] SEN_ADDR = (XLEN == 32) ? 12'h31C : 12'h30C;
  localparam logic [11:0] SEN_LO   = 12'h30C;
  localparam int          SEN_BIT  = (XLEN == 32) ? 23 : 55;
  localparam int          TAG_W    = 12;
  localparam int          MC_LSB   = 16;

  logic [TAG_W-1:0] rcid, mcid;
  logic             sen;

  logic            is_m, is_s, req;
  logic            hit_qos, hit_sen, hit_lo, allowed, do_write;
  logic [XLEN-1:0] qos_view, sen_view, cur, newv;

  assign is_m    = req_priv == 2'b11;
  assign is_s    = req_priv == 2'b01;
  assign req     = req_op != 2'b00;
  assign hit_qos = req_addr == QOS_ADDR;
  assign hit_sen = req_addr == SEN_ADDR;
  assign hit_lo  = (XLEN == 32) && (req_addr == SEN_LO);

  always_comb begin
    qos_view = '0;
    qos_view[TAG_W-1:0] = rcid;
    qos_view[MC_LSB +: TAG_W] = mcid;
    sen_view = '0;
    sen_view[SEN_BIT] = sen;
  end

  assign allowed = hit_qos ? (is_m | (is_s & sen)) :
                   (hit_sen | hit_lo) ? is_m : 1'b0;
  assign illegal = req & ~allowed;

  assign cur = hit_qos ? qos_view : hit_sen ? sen_view : '0;
  assign rd_data = (req & allowed) ? cur : '0;

  always_comb begin
    case (req_op)
      2'b01:   newv = req_wdata;
      2'b10:   newv = cur | req_wdata;
      default: newv = cur & ~req_wdata;
    endcase
  end

  assign do_write = req & allowed & ((req_op == 2'b01) | (|req_wdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcid <= '0;
      mcid <= '0;
      sen  <= 1'b0;
    end else if (do_write) begin
      if (hit_qos) begin
        rcid <= newv[TAG_W-1:0];
        mcid <= newv[MC_LSB +: TAG_W];
      end
      if (hit_sen) sen <= newv[SEN_BIT];
    end
  end

  assert_illegal_holds_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(rcid) && $stable(mcid) && $stable(sen)));

  assert_user_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit_qos && req_priv == 2'b00) |-> illegal);

  assert_sup_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit_qos && is_s) |-> (illegal == !sen));

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 2'b01 && hit_qos && is_m) |=>
      (rcid == $past(req_wdata[11:0]) && mcid == $past(req_wdata[27:16])));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:12] == 4'b0) || !hit_qos);

  assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op[1] && req_wdata == '0) |=>
      ($stable(rcid) && $stable(mcid) && $stable(sen)));

  assert_sen_machine_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit_sen && !is_m) |-> illegal);
endmodule

// File: tb/sim_qos_tag_csr.sv
module sim_qos_tag_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_op = '0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_priv = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data;
  logic        illegal;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  qos_tag_csr #(.XLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_priv(req_priv), .req_wdata(req_wdata), .rd_data(rd_data), .illegal(illegal)
  );

  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;
  localparam logic [1:0] WR = 2'b01, ST = 2'b10, CL = 2'b11;
  localparam logic [63:0] B55 = 64'h0080_0000_0000_0000;

  // {priv, addr, op, wdata, expected rd, expected illegal}
  localparam int NV = 19;
  localparam logic [144:0] VEC [NV] = '{
    {M, 12'h181, WR, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,         1'b0}, // R3 R4
    {M, 12'h181, ST, 64'h0,                   64'h0FFF_0FFF, 1'b0}, // R2 R6
    {M, 12'h181, CL, 64'h00F0_00F0,           64'h0FFF_0FFF, 1'b0}, // R5
    {S, 12'h181, WR, 64'h1234,                64'h0,         1'b1}, // R7
    {U, 12'h181, ST, 64'h1,                   64'h0,         1'b1}, // R8
    {S, 12'h30C, ST, B55,                     64'h0,         1'b1}, // R9
    {M, 12'h30C, ST, B55,                     64'h0,         1'b0}, // R9
    {M, 12'h30C, ST, 64'h0,                   B55,           1'b0}, // R9
    {S, 12'h181, WR, 64'h0ABC_0123,           64'h0F0F_0F0F, 1'b0}, // R7 R10
    {S, 12'h181, ST, 64'h0001_0000,           64'h0ABC_0123, 1'b0}, // R5
    {U, 12'h181, WR, 64'h0,                   64'h0,         1'b1}, // R8 R10
    {M, 12'h181, CL, 64'h0,                   64'h0ABD_0123, 1'b0}, // R6
    {M, 12'h3C0, WR, 64'h0,                   64'h0,         1'b1}, // R11
    {M, 12'h30C, CL, B55,                     B55,           1'b0}, // R9
    {S, 12'h181, CL, 64'h0,                   64'h0,         1'b1}, // R7
    {M, 12'h181, WR, 64'hFFFF_FFFF_F000_F000, 64'h0ABD_0123, 1'b0}, // R4
    {M, 12'h181, ST, 64'h0,                   64'h0,         1'b0}, // R4
    {M, 12'h30C, WR, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,         1'b0}, // R9
    {M, 12'h30C, ST, 64'h0,                   B55,           1'b0}  // R9
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] p, input logic [11:0] a, input logic [1:0] o,
                       input logic [63:0] d);
    @(negedge clk);
    req_priv = p; req_addr = a; req_op = o; req_wdata = d;
    #5;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    apply(M, 12'h181, ST, 64'h0);
    chk("R1 tags after reset", rd_data, 64'h0);
    apply(M, 12'h30C, ST, 64'h0);
    chk("R1 enable after reset", rd_data, 64'h0);
    apply(S, 12'h181, ST, 64'h0);
    chk("R7 blocked after reset", {63'b0, illegal}, 64'h1);
    apply(M, 12'h181, 2'b00, 64'hFFFF);
    chk("R11 idle illegal", {63'b0, illegal}, 64'h0);
    chk("R11 idle rd_data", rd_data, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][144:143], VEC[i][142:131], VEC[i][130:129], VEC[i][128:65]);
      chk($sformatf("R2/R5 vec %0d rd_data", i), rd_data, VEC[i][64:1]);
      chk($sformatf("R10 vec %0d illegal", i), {63'b0, illegal}, {63'b0, VEC[i][0]});
    end

    apply(S, 12'h181, WR, 64'h0555_0AAA);
    apply(S, 12'h181, ST, 64'h0);
    chk("R3 supervisor write readback", rd_data, 64'h0555_0AAA);

    @(negedge clk);
    req_op = 2'b00;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(M, 12'h181, ST, 64'h0);
    chk("R1 tags after second reset", rd_data, 64'h0);
    apply(S, 12'h181, ST, 64'h0);
    chk("R7 enable cleared by reset", {63'b0, illegal}, 64'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule